// File: doc/BRIEF.md
# Overlapping-Reset Phase Frequency Detector

This block compares two already-divided pulse trains, one from the reference divider and one from the feedback (VCO) divider. It drives two charge-pump control lines, a pump-up line and a pump-down line, that feed an external integrating loop filter. The inputs are taken to be synchronous to `clk`, so any synchronising stage sits outside the block. A rising edge on the reference input raises the pump-up line and a rising edge on the feedback input raises the pump-down line. Once both lines are raised, a short clear interval of `OVERLAP` clocks keeps both high together before they drop. Because the clear interval has a fixed length, even a near-zero phase error produces a measurable pulse on each line, so the detector has no dead zone at the crossover.

A mode input can switch the outputs to an exclusive-OR phase detector. In that mode, each input drives a toggle flip-flop, pump-up carries the XOR of the two toggles, and pump-down carries its inverse. The phase frequency detector keeps running in both modes. A lock monitor watches it and raises `locked` after `LOCK_N` consecutive comparisons with short pulses.

The controller is a four-state machine:
- `ST_IDLE`: neither line is raised.
- `ST_UP`: only the reference has arrived.
- `ST_DN`: only the feedback has arrived.
- `ST_CLR`: both lines are held high while the clear counter runs.

Its transitions are:
- *ref-arrive*: `ST_IDLE`→`ST_UP`.
- *fb-arrive*: `ST_IDLE`→`ST_DN`.
- *coincide*: `ST_IDLE`→`ST_CLR`, when both edges arrive in the same cycle.
- *close-up*: `ST_UP`→`ST_CLR`, on a feedback edge.
- *close-dn*: `ST_DN`→`ST_CLR`, on a reference edge.
- *release*: `ST_CLR`→`ST_IDLE`.
- *carry-ref*: `ST_CLR`→`ST_UP`, when a reference edge was held during the clear.
- *carry-fb*: `ST_CLR`→`ST_DN`, when a feedback edge was held during the clear.
- *recoincide*: `ST_CLR`→`ST_CLR`, when both edges were held.

Top module: `dzf_pfd`

## Requirements
- R1: After reset, with `mode_xor`=0, `pump_up` and `pump_dn` are both 0 and `locked` is 0.
- R2: With `mode_xor`=0, a rising edge on `ref_in` sampled at clock edge k makes `pump_up`=1 after edge k while `pump_dn` stays 0. A rising edge on `fb_in` does the same for `pump_dn`, with `pump_up` staying 0.
- R3: Once the second input's edge is sampled, or both edges are sampled at the same clock edge, both outputs are 1 for exactly `OVERLAP` clock cycles (default 2).
- R4: After the overlap, both outputs drop to 0 at the same clock edge, unless an edge was held (see R5).
- R5: A rising edge that arrives during the overlap, including its last cycle, is not lost. After the clear, the output for that input is 1 and the other output is 0.
- R6: A comparison is good when neither output was high for more than `OVERLAP`+2 cycles within it. `locked` becomes 1 right after the `LOCK_N`-th (default 16) consecutive good comparison, and not before.
- R7: A single comparison that is not good clears `locked` after that comparison ends, and the count of good comparisons starts again from zero.
- R8: With `mode_xor`=1, each rising edge on an input flips a toggle bit one clock later. `pump_up` equals the XOR of the two toggle bits, with both bits at 0 after reset, and `pump_dn` is the inverse of `pump_up`. Edges that arrive on both inputs in the same cycle leave `pump_up` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. |
| rst_n | input | 1 | Active-low synchronous reset. |
| ref_in | input | 1 | Divided reference pulse train, synchronous to clk. |
| fb_in | input | 1 | Divided VCO pulse train, synchronous to clk. |
| mode_xor | input | 1 | 0 selects the phase frequency detector, 1 selects the XOR detector. |
| pump_up | output | 1 | Pump-up charge-pump control. |
| pump_dn | output | 1 | Pump-down charge-pump control. |
| locked | output | 1 | Lock indication. |

## Verification
Two functions can fall in the same cycle: the end of the overlap clear, and the arrival of a new input edge that must be carried into the next comparison. The bench provokes this by raising the reference input again in each overlap cycle in turn, including the exact cycle in which the clear completes. In every case it expects `pump_up` alone to be high just after the clear. A second case of the same kind is the end of a comparison and the lock decision. The bench judges this on the 15th and 16th good comparisons, the boundary lead of two cycles, and the first comparison with a lead of three cycles.

// File: rtl/dzf_pkg.sv
package dzf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DN   = 2'd2,
        ST_CLR  = 2'd3
    } pfd_state_e;
endpackage

// File: rtl/dzf_edge.sv
module dzf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/dzf_xor.sv
module dzf_xor (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_r_i,
    input  logic rise_f_i,
    output logic xor_o
);
    logic tog_r_q, tog_f_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_r_q <= 1'b0;
            tog_f_q <= 1'b0;
        end else begin
            if (rise_r_i) tog_r_q <= ~tog_r_q;
            if (rise_f_i) tog_f_q <= ~tog_f_q;
        end
    end

    assign xor_o = tog_r_q ^ tog_f_q;

    // R8
    xor_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_r_i != rise_f_i) |=> (xor_o != $past(xor_o)));
endmodule

// File: rtl/dzf_fsm.sv
module dzf_fsm
    import dzf_pkg::*;
#(
    parameter int OVERLAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_r_i,
    input  logic rise_f_i,
    output logic up_o,
    output logic dn_o,
    output logic done_o
);
    localparam int CW = (OVERLAP > 1) ? $clog2(OVERLAP) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERLAP - 1);

    pfd_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic pend_r_q, pend_f_q, pend_r_d, pend_f_d;
    logic carry_r, carry_f;

    assign done_o  = (state_q == ST_CLR) && (cnt_q == LAST);
    assign carry_r = pend_r_q | rise_r_i;
    assign carry_f = pend_f_q | rise_f_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            pend_r_q <= 1'b0;
            pend_f_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            pend_r_q <= pend_r_d;
            pend_f_q <= pend_f_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = '0;
        pend_r_d = 1'b0;
        pend_f_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (rise_r_i && rise_f_i) state_d = ST_CLR;
                else if (rise_r_i)        state_d = ST_UP;
                else if (rise_f_i)        state_d = ST_DN;
            end
            ST_UP: if (rise_f_i) state_d = ST_CLR;
            ST_DN: if (rise_r_i) state_d = ST_CLR;
            ST_CLR: begin
                if (cnt_q == LAST) begin
                    if (carry_r && carry_f) state_d = ST_CLR;
                    else if (carry_r)       state_d = ST_UP;
                    else if (carry_f)       state_d = ST_DN;
                    else                    state_d = ST_IDLE;
                end else begin
                    cnt_d    = cnt_q + 1'b1;
                    pend_r_d = carry_r;
                    pend_f_d = carry_f;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        up_o = 1'b0;
        dn_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_UP:   up_o = 1'b1;
            ST_DN:   dn_o = 1'b1;
            ST_CLR: begin
                up_o = 1'b1;
                dn_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R2
    up_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rise_r_i && !rise_f_i) |=> (up_o && !dn_o));
    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLR) |-> (cnt_q <= LAST));
    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !carry_r && !carry_f) |=> (!up_o && !dn_o));
    // R5
    carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && carry_r && !carry_f) |=> (up_o && !dn_o));
endmodule

// File: rtl/dzf_lock.sv
module dzf_lock #(
    parameter int OVERLAP = 2,
    parameter int LOCK_N  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic dn_i,
    input  logic done_i,
    output logic locked_o
);
    localparam int LW = $clog2(OVERLAP + 3) + 1;
    localparam int GW = $clog2(LOCK_N + 1);
    localparam logic [LW-1:0] LEN_MAX = '1;
    localparam logic [LW-1:0] LEN_OK  = LW'(OVERLAP + 1);
    localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_N - 1);

    logic [LW-1:0] up_len_q, dn_len_q;
    logic [GW-1:0] good_q;
    logic good;

    assign good = (up_len_q <= LEN_OK) && (dn_len_q <= LEN_OK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_len_q <= '0;
            dn_len_q <= '0;
            good_q   <= '0;
            locked_o <= 1'b0;
        end else if (done_i) begin
            up_len_q <= '0;
            dn_len_q <= '0;
            if (good) begin
                if (good_q < GW'(LOCK_N)) good_q <= good_q + 1'b1;
                if (good_q >= GOOD_LAST)  locked_o <= 1'b1;
            end else begin
                good_q   <= '0;
                locked_o <= 1'b0;
            end
        end else begin
            if (up_i && up_len_q != LEN_MAX) up_len_q <= up_len_q + 1'b1;
            if (dn_i && dn_len_q != LEN_MAX) dn_len_q <= dn_len_q + 1'b1;
        end
    end

    // R7
    bad_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !good) |=> !locked_o);
    // R6
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(done_i));
endmodule

// File: rtl/dzf_pfd.sv
module dzf_pfd #(
    parameter int OVERLAP = 2,
    parameter int LOCK_N  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic mode_xor,
    output logic pump_up,
    output logic pump_dn,
    output logic locked
);
    logic rise_r, rise_f, up_p, dn_p, done, xor_s;

    dzf_edge u_edge_r (.clk(clk), .rst_n(rst_n), .sig_i(ref_in), .rise_o(rise_r));
    dzf_edge u_edge_f (.clk(clk), .rst_n(rst_n), .sig_i(fb_in),  .rise_o(rise_f));

    dzf_fsm #(.OVERLAP(OVERLAP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rise_r_i(rise_r), .rise_f_i(rise_f),
        .up_o(up_p), .dn_o(dn_p), .done_o(done)
    );

    dzf_xor u_xor (
        .clk(clk), .rst_n(rst_n), .rise_r_i(rise_r), .rise_f_i(rise_f), .xor_o(xor_s)
    );

    dzf_lock #(.OVERLAP(OVERLAP), .LOCK_N(LOCK_N)) u_lock (
        .clk(clk), .rst_n(rst_n), .up_i(up_p), .dn_i(dn_p), .done_i(done),
        .locked_o(locked)
    );

    assign pump_up = mode_xor ? xor_s  : up_p;
    assign pump_dn = mode_xor ? ~xor_s : dn_p;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        (!rst_n && !mode_xor) |=> (!pump_up && !pump_dn && !locked));
endmodule

// File: tb/tb_dzf_pfd.sv
module tb_dzf_pfd;
    localparam int CLK_P = 10;
    localparam int OV    = 2;
    localparam int LOCKN = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, mode_xor = 1'b0;
    logic pump_up, pump_dn, locked;
    int checks = 0, fails = 0;
    bit tr = 1'b0, tf = 1'b0;

    dzf_pfd #(.OVERLAP(OV), .LOCK_N(LOCKN)) dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .mode_xor(mode_xor), .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tr = 1'b0; tf = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        mode_xor = 1'b0;
        do_reset();
        chk("R1 up", pump_up, 1'b0);
        chk("R1 dn", pump_dn, 1'b0);
        chk("R1 lock", locked, 1'b0);
    endtask

    // one comparison; lead 0 = coincident edges
    task automatic cmp(input bit ref_lead, input int lead,
                       input bit chk_lock, input logic exp_lock);
        @(negedge clk);
        if (lead == 0) begin
            ref_in = 1'b1; fb_in = 1'b1;
        end else begin
            if (ref_lead) ref_in = 1'b1; else fb_in = 1'b1;
            for (int i = 0; i < lead; i++) begin
                @(negedge clk);
                chk("R2 leader", ref_lead ? pump_up : pump_dn, 1'b1);
                chk("R2 other", ref_lead ? pump_dn : pump_up, 1'b0);
            end
            if (ref_lead) fb_in = 1'b1; else ref_in = 1'b1;
        end
        for (int i = 0; i < OV; i++) begin
            @(negedge clk);
            chk("R3 up", pump_up, 1'b1);
            chk("R3 dn", pump_dn, 1'b1);
        end
        @(negedge clk);
        chk("R4 up", pump_up, 1'b0);
        chk("R4 dn", pump_dn, 1'b0);
        if (chk_lock) chk("R6_R7 lock", locked, exp_lock);
        ref_in = 1'b0; fb_in = 1'b0;
        @(negedge clk);
    endtask

    // R5: new ref edge during overlap cycle 'at'
    task automatic t_pending(input int at);
        @(negedge clk); ref_in = 1'b1;
        @(negedge clk); fb_in = 1'b1; ref_in = 1'b0;
        for (int k = 0; k < OV; k++) begin
            @(negedge clk);
            chk("R5 both", pump_up & pump_dn, 1'b1);
            if (k == 0) fb_in = 1'b0;
            if (k == at) ref_in = 1'b1;
        end
        @(negedge clk);
        chk("R5 up held", pump_up, 1'b1);
        chk("R5 dn low", pump_dn, 1'b0);
        fb_in = 1'b1;
        for (int k = 0; k < OV; k++) begin
            @(negedge clk);
            chk("R5 close", pump_up & pump_dn, 1'b1);
        end
        @(negedge clk);
        chk("R5 idle", pump_up | pump_dn, 1'b0);
        ref_in = 1'b0; fb_in = 1'b0;
        @(negedge clk);
    endtask

    // R6 and R7
    task automatic t_lock();
        cmp(1'b1, 3, 1'b1, 1'b0);
        for (int n = 1; n <= LOCKN; n++)
            cmp(n[0], n % 3, 1'b1, (n == LOCKN) ? 1'b1 : 1'b0);
        cmp(1'b1, 2, 1'b1, 1'b1);
        cmp(1'b0, 3, 1'b1, 1'b0);
        cmp(1'b1, 1, 1'b1, 1'b0);
    endtask

    // R8
    task automatic xedge(input bit r, input bit f);
        @(negedge clk);
        ref_in = r; fb_in = f;
        @(negedge clk);
        if (r) tr = ~tr;
        if (f) tf = ~tf;
        chk("R8 up", pump_up, tr ^ tf);
        chk("R8 dn", pump_dn, ~(tr ^ tf));
        ref_in = 1'b0; fb_in = 1'b0;
    endtask

    task automatic t_xor();
        mode_xor = 1'b1;
        do_reset();
        chk("R8 reset up", pump_up, 1'b0);
        chk("R8 reset dn", pump_dn, 1'b1);
        xedge(1'b1, 1'b0);
        xedge(1'b0, 1'b1);
        xedge(1'b1, 1'b0);
        xedge(1'b1, 1'b1);
        xedge(1'b1, 1'b0);
        xedge(1'b0, 1'b1);
        mode_xor = 1'b0;
    endtask

    initial begin
        t_reset();
        cmp(1'b1, 1, 1'b0, 1'b0);
        cmp(1'b0, 2, 1'b0, 1'b0);
        cmp(1'b1, 0, 1'b0, 1'b0);
        for (int a = 0; a < OV; a++) t_pending(a);
        t_lock();
        t_xor();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule